// File: doc/BRIEF.md
# Clock Output Gating and Audio Clock Select

This block sits between a set of free-running synthesized clocks and the output pads of a clock generator. It serves five outputs: a reference clock, a spread-spectrum processor clock, a 48 MHz clock, a fixed 22.5792 MHz audio clock, and an audio clock that can be switched between 22.5792 MHz and 24.576 MHz. For each output it drives a data value and a pad drive-enable. It also drives power-down requests for the PLLs behind two of the outputs.

A single float input places every pad in high impedance. Per-output enable bits, taken from a control register outside the block, hold a disabled output low while its pad keeps driving. Enable changes pass through a two-stage synchronizer clocked on the falling edge of the output's own source. A change therefore takes effect only while that clock is low, and a high phase is never cut short.

A select bit picks the source for the switchable audio output. The switch uses a cross-coupled handshake with two flops per source. The old clock finishes its cycle, the output rests low, and then the new clock starts with a full cycle.

Top module: `clkout_ctrl`

## Requirements
- R1: When `float_req` is 1, every bit of `clk_oe` is 0. When it is 0, every bit of `clk_oe` is 1. Output index order is 0 reference, 1 spread, 2 48 MHz, 3 fixed audio, 4 switchable audio.
- R2: An output whose enable bit is 1 reproduces its source clock exactly, starting no later than the second falling edge of that source after the bit is set.
- R3: An output whose enable bit is 0 is held at 0 from the second falling edge of its source, and its `clk_oe` bit is unaffected.
- R4: `pll_pd[0]` is the inverse of enable bit 1 (spread), and `pll_pd[1]` is the inverse of enable bit 3 (fixed audio). Enable bits 0, 2 and 4 have no power-down output.
- R5: Toggling an enable bit never produces a high pulse on that output shorter than the source's high phase.
- R6: With `aud_sel` = 1, output 4 carries the 24.576 MHz source `src_aud24`. With `aud_sel` = 0, it carries the 22.5792 MHz source `src_aud22`.
- R7: On a change of `aud_sel`, output 4 shows no high or low phase shorter than the shorter of the two sources' half periods. The two source-release states are never active together.
- R8: While `rst_n` is 0, whatever the enable and select inputs are, outputs 0, 1, 2 and 4 are enabled, output 3 is held low, and output 4 carries `src_aud24`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per source domain |
| float_req | input | 1 | 1 puts all pads in high impedance |
| src_ref | input | 1 | Reference source clock |
| src_spr | input | 1 | Spread processor source clock |
| src_usb | input | 1 | 48 MHz source clock |
| src_aud22 | input | 1 | 22.5792 MHz audio source clock |
| src_aud24 | input | 1 | 24.576 MHz audio source clock |
| out_en | input | 5 | Per-output enable bits, index order as in R1 |
| aud_sel | input | 1 | Source select for output 4 |
| clk_val | output | 5 | Output clock data values |
| clk_oe | output | 5 | Pad drive-enables, 1 = driving |
| pll_pd | output | 2 | PLL power-down requests: bit 0 spread, bit 1 fixed audio |

## Verification
The results fall due at three different times.

- `clk_oe` and `pll_pd` are combinational. The bench checks them one time step after it drives `float_req` or `out_en`.
- An enable change is due by the second falling edge of the affected source. The slowest source has a 44 ns period, so the bench waits 150 ns before it compares a 40-sample window against its own copy of the source.
- A select change needs a rising and a falling edge of the old source, then the same on the new source. The bench waits 400 ns before it compares. Meanwhile, edge-time monitors record the shortest high and low phases on outputs 1 and 4 throughout the toggling sequences.

All comparisons sample at times offset from every source edge.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/100ps
package clkgate_pkg;
  localparam int NUM_OUT = 5;
  localparam int NUM_PD  = 2;
  // output index order; the bench relies on it
  localparam int IDX_REF = 0;
  localparam int IDX_SPR = 1;
  localparam int IDX_USB = 2;
  localparam int IDX_FIX = 3;
  localparam int IDX_SEL = 4;
  // power-down request order
  localparam int PD_SPR = 0;
  localparam int PD_FIX = 1;
  // reset enables: fixed audio off, all others on
  localparam logic [NUM_OUT-1:0] EN_DEFAULT = 5'b10111;
endpackage

// File: rtl/clkgate_rst_sync.sv
`timescale 1ns/100ps
module clkgate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_d;

  always_comb q_d = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign rst_n_o = q[STAGES-1];
endmodule

// File: rtl/clkgate_cell.sv
`timescale 1ns/100ps
module clkgate_cell #(
  parameter bit EN_RST = 1'b1
) (
  input  logic src_clk,
  input  logic arst_n,
  input  logic en_in,
  output logic clk_out
);
  localparam int SYNC = 2;

  logic            rst_q;
  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;

  clkgate_rst_sync #(.STAGES(2)) u_rst (
    .clk     (src_clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_q)
  );

  // enable moves only while the source is low
  always_comb sync_d = {sync_q[SYNC-2:0], en_in};

  always_ff @(negedge src_clk or negedge rst_q) begin
    if (!rst_q) sync_q <= {SYNC{EN_RST}};
    else        sync_q <= sync_d;
  end

  assign clk_out = src_clk & sync_q[SYNC-1];

  // R3
  gate_off_chk: assert property (@(negedge src_clk) disable iff (!rst_q)
    ($past(rst_q, 2) && $past(rst_q) && !$past(en_in, 2) && !$past(en_in)) |-> !clk_out);

  // R2
  gate_on_chk: assert property (@(negedge src_clk) disable iff (!rst_q)
    ($past(rst_q, 2) && $past(rst_q) && $past(en_in, 2) && $past(en_in)) |-> clk_out);
endmodule

// File: rtl/clkgate_gfmux.sv
`timescale 1ns/100ps
module clkgate_gfmux #(
  parameter bit SEL_RST = 1'b1
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic arst_n,
  input  logic sel,
  output logic clk_out
);
  logic rst_a, rst_b;
  logic arm_a, arm_b, hold_a, hold_b;
  logic req_a, req_b;

  clkgate_rst_sync #(.STAGES(2)) u_rst_a (.clk(clk_a), .arst_n(arst_n), .rst_n_o(rst_a));
  clkgate_rst_sync #(.STAGES(2)) u_rst_b (.clk(clk_b), .arst_n(arst_n), .rst_n_o(rst_b));

  // each side may claim the output only once the other has released it
  always_comb begin
    req_a = ~sel & ~hold_b;
    req_b =  sel & ~hold_a;
  end

  always_ff @(posedge clk_a or negedge rst_a) begin
    if (!rst_a) arm_a <= ~SEL_RST;
    else        arm_a <= req_a;
  end

  always_ff @(negedge clk_a or negedge rst_a) begin
    if (!rst_a) hold_a <= ~SEL_RST;
    else        hold_a <= arm_a;
  end

  always_ff @(posedge clk_b or negedge rst_b) begin
    if (!rst_b) arm_b <= SEL_RST;
    else        arm_b <= req_b;
  end

  always_ff @(negedge clk_b or negedge rst_b) begin
    if (!rst_b) hold_b <= SEL_RST;
    else        hold_b <= arm_b;
  end

  assign clk_out = (clk_a & hold_a) | (clk_b & hold_b);

  // R7
  excl_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a) hold_a |-> !hold_b);
  // R7
  excl_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b) hold_b |-> !hold_a);
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/100ps
module clkout_ctrl
  import clkgate_pkg::*;
#(
  parameter logic [NUM_OUT-1:0] EN_RESET  = EN_DEFAULT,
  parameter bit                 SEL_RESET = 1'b1
) (
  input  logic               rst_n,
  input  logic               float_req,
  input  logic               src_ref,
  input  logic               src_spr,
  input  logic               src_usb,
  input  logic               src_aud22,
  input  logic               src_aud24,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic               aud_sel,
  output logic [NUM_OUT-1:0] clk_val,
  output logic [NUM_OUT-1:0] clk_oe,
  output logic [NUM_PD-1:0]  pll_pd
);
  logic               sel_clk;
  logic [NUM_OUT-1:0] src_vec;

  clkgate_gfmux #(.SEL_RST(SEL_RESET)) u_mux (
    .clk_a   (src_aud22),
    .clk_b   (src_aud24),
    .arst_n  (rst_n),
    .sel     (aud_sel),
    .clk_out (sel_clk)
  );

  always_comb begin
    src_vec          = '0;
    src_vec[IDX_REF] = src_ref;
    src_vec[IDX_SPR] = src_spr;
    src_vec[IDX_USB] = src_usb;
    src_vec[IDX_FIX] = src_aud22;
    src_vec[IDX_SEL] = sel_clk;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    clkgate_cell #(.EN_RST(EN_RESET[g])) u_cell (
      .src_clk (src_vec[g]),
      .arst_n  (rst_n),
      .en_in   (out_en[g]),
      .clk_out (clk_val[g])
    );
    assign clk_oe[g] = ~float_req;
  end

  // only the spread and fixed-audio PLLs are shut off with their outputs
  always_comb begin
    pll_pd         = '0;
    pll_pd[PD_SPR] = ~out_en[IDX_SPR];
    pll_pd[PD_FIX] = ~out_en[IDX_FIX];
  end
endmodule

// File: tb/clkout_ctrl_tb_top.sv
`timescale 1ns/100ps
module clkout_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic float_req = 1'b0;
  logic s_ref = 1'b0, s_spr = 1'b0, s_usb = 1'b0, s_a22 = 1'b0, s_a24 = 1'b0;
  logic [4:0] out_en = 5'b00000;
  logic aud_sel = 1'b0;
  logic [4:0] clk_val, clk_oe;
  logic [1:0] pll_pd;

  int checks = 0;
  int errors = 0;

  clkout_ctrl dut_i (
    .rst_n(rst_n), .float_req(float_req),
    .src_ref(s_ref), .src_spr(s_spr), .src_usb(s_usb),
    .src_aud22(s_a22), .src_aud24(s_a24),
    .out_en(out_en), .aud_sel(aud_sel),
    .clk_val(clk_val), .clk_oe(clk_oe), .pll_pd(pll_pd)
  );

  always #5 clk = ~clk;
  initial begin #0.3; forever #19 s_ref = ~s_ref; end
  initial begin #0.3; forever #13 s_spr = ~s_spr; end
  initial begin #0.3; forever #10 s_usb = ~s_usb; end
  initial begin #0.3; forever #22 s_a22 = ~s_a22; end
  initial begin #0.3; forever #20 s_a24 = ~s_a24; end

  // phase-width monitors on outputs 1 and 4
  realtime t_rise[2], t_fall[2];
  bit      have_rise[2], have_fall[2];
  real     min_hi[2], min_lo[2];

  task automatic mon_clear();
    for (int m = 0; m < 2; m++) begin
      have_rise[m] = 0; have_fall[m] = 0; min_hi[m] = 1.0e9; min_lo[m] = 1.0e9;
    end
  endtask

  task automatic mon_edge(input int m, input bit rising);
    real w;
    if (rising) begin
      if (have_fall[m]) begin w = $realtime - t_fall[m]; if (w < min_lo[m]) min_lo[m] = w; end
      t_rise[m] = $realtime; have_rise[m] = 1;
    end else begin
      if (have_rise[m]) begin w = $realtime - t_rise[m]; if (w < min_hi[m]) min_hi[m] = w; end
      t_fall[m] = $realtime; have_fall[m] = 1;
    end
  endtask

  always @(posedge clk_val[1]) mon_edge(0, 1'b1);
  always @(negedge clk_val[1]) mon_edge(0, 1'b0);
  always @(posedge clk_val[4]) mon_edge(1, 1'b1);
  always @(negedge clk_val[4]) mon_edge(1, 1'b0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic src_bit(input int idx, input bit sel_exp);
    case (idx)
      0: return s_ref;
      1: return s_spr;
      2: return s_usb;
      3: return s_a22;
      default: return sel_exp ? s_a24 : s_a22;
    endcase
  endfunction

  // compare one output against its expected waveform over 40 samples
  task automatic cmp_out(input int idx, input bit en_exp, input bit sel_exp, input string req);
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (clk_val[idx] !== (en_exp ? src_bit(idx, sel_exp) : 1'b0)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  // R8: defaults are held during reset, whatever the inputs say
  task automatic t_reset();
    out_en = 5'b00000; aud_sel = 1'b0; rst_n = 1'b0;
    #300;
    cmp_out(0, 1, 1, "R8 ref on in reset");
    cmp_out(1, 1, 1, "R8 spread on in reset");
    cmp_out(2, 1, 1, "R8 48M on in reset");
    cmp_out(3, 0, 1, "R8 fixed audio low in reset");
    cmp_out(4, 1, 1, "R8 select output on 24M in reset");
    out_en = 5'b10111; aud_sel = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    #300;
  endtask

  // R1
  task automatic t_float();
    float_req = 1'b1; #1;
    check(clk_oe == 5'b00000, "R1 float high", clk_oe, 0);
    float_req = 1'b0; #1;
    check(clk_oe == 5'b11111, "R1 float low", clk_oe, 31);
  endtask

  // R2 R3: enable patterns; R4 power-down follows the bits
  task automatic t_pattern(input logic [4:0] pat);
    out_en = pat; #1;
    check(pll_pd == {~pat[3], ~pat[1]}, "R4 power-down", pll_pd, {~pat[3], ~pat[1]});
    #150;
    for (int i = 0; i < 5; i++)
      cmp_out(i, pat[i], 1'b1, pat[i] ? "R2 enabled output follows source" : "R3 disabled output low");
    check(clk_oe == 5'b11111, "R3 disabled output still driven", clk_oe, 31);
  endtask

  // R5: high phases never truncated by enable toggling
  task automatic t_trunc();
    mon_clear();
    for (int k = 0; k < 40; k++) begin
      #37; out_en[1] = ~out_en[1]; out_en[4] = ~out_en[4];
    end
    out_en = 5'b11111; #200;
    check(min_hi[0] > 12.9, "R5 spread high phase", int'(min_hi[0]), 13);
    check(min_hi[1] > 19.9, "R5 select output high phase", int'(min_hi[1]), 20);
  endtask

  // R6 R7: source select and glitch-free switching
  task automatic t_select();
    out_en = 5'b11111; #150;
    mon_clear();
    for (int k = 0; k < 4; k++) begin
      aud_sel = 1'b0; #400;
      cmp_out(4, 1, 0, "R6 select 0 gives 22M source");
      aud_sel = 1'b1; #400;
      cmp_out(4, 1, 1, "R6 select 1 gives 24M source");
    end
    aud_sel = 1'b0; #97; aud_sel = 1'b1; #53; aud_sel = 1'b0; #400;
    cmp_out(4, 1, 0, "R6 settles after quick toggles");
    check(min_hi[1] > 19.9, "R7 no runt high", int'(min_hi[1]), 20);
    check(min_lo[1] > 19.9, "R7 no runt low", int'(min_lo[1]), 20);
  endtask

  initial begin
    #200_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_float();
    t_pattern(5'b11111);
    t_pattern(5'b00000);
    t_pattern(5'b10101);
    t_pattern(5'b01010);
    t_trunc();
    t_select();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule